// File: doc/BRIEF.md
# Static Memory Bank Decoder and Access Timer

This block sits between a system address and an external static-memory bus. A 30-bit request address is split into eight 128 MB windows. The lower seven windows belong to banks 0 to 6 at fixed places. Bank 7 lives in the top window, and only the range given by its programmable base and size answers there. When a request hits, the block asserts that bank's select. It reports the bank's programmed bus width and the offset inside the bank. It then holds the select for the bank's programmed number of cycles, plus any cycles in which the external wait input is high. A one-cycle done pulse closes the access. A request that hits no bank produces a one-cycle error pulse and no select.

Configuration goes through a simple write port. Select values 0 to 7 address the per-bank timing registers: cycle count in data bits [4:0], width code in bits [9:8]. Select 8 takes bank 7's base and select 9 takes its size. Both are counted in 1 MB granules.

The sequencer has four states:
- IDLE waits for a request.
- ACTIVE drives the select and counts.
- FINISH pulses done.
- FAULT pulses the error.

Its transitions are:
- start: IDLE to ACTIVE on a hit.
- miss: IDLE to FAULT.
- expire: ACTIVE to FINISH when the count is zero and wait is low.
- release: FINISH to IDLE.
- recover: FAULT to IDLE.

Top module: `mem_bank_ctl`

## Requirements
- R1: After reset, busy, done and err are 0 and no bank select is driven. Every bank holds width code 00 and cycle count 31. Bank 7 covers the whole top window: base 896, size 128.
- R2: An address whose top three bits are 0 to 6 selects that bank. bank_sel is one-hot with bit i for bank i. local_off equals address bits [26:0].
- R3: Bank 7 answers for an address in the top window whose 1 MB granule number g (address bits [29:20]) satisfies base <= g < base+size. Its local_off is the low 27 bits of the address minus base*2^20. A size of 0 gives an empty window.
- R4: When bank 7's window reaches into a fixed bank's window, an address there selects the fixed bank.
- R5: A request that hits no bank drives err high for exactly one cycle, starting the cycle after the request. No select is driven, and busy returns low the cycle after.
- R6: With wait low, bank_sel stays asserted for N+1 cycles, where N is the bank's 5-bit cycle count. done is high for one cycle right after, with bank_sel low. busy then falls.
- R7: Each cycle in which wait_in is high during an access adds exactly one cycle to the select time.
- R8: During an access, bus_width shows the bank's width code: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit.
- R9: A bank register write whose width field [9:8] is 11 is dropped entirely. Neither width nor cycle count changes.
- R10: A request that arrives while an access is in progress is ignored. The current access keeps its bank and timing, and no second access follows.
- R11: A bank's width and count are captured when its access starts. A register write during the access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0-7 bank timing, 8 bank-7 base, 9 bank-7 size |
| cfg_wdata | input | 10 | Configuration write data |
| req | input | 1 | Access request, sampled in IDLE |
| addr | input | 30 | Request address |
| wait_in | input | 1 | External wait, stretches the access while high |
| bank_sel | output | 8 | One-hot bank select, active during ACTIVE |
| bus_width | output | 2 | Width code of the bank being accessed |
| local_off | output | 27 | Offset of the access inside its bank |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle access completion pulse |
| err | output | 1 | One-cycle no-bank pulse |

## Verification
A corrupted down-counter shows up within one access as a select time that differs from N+1 plus the wait count. The bench catches this when it sweeps every cycle value on one bank. A wrong latched bank index or offset shows on the first sampled cycle of the access as a wrong select bit or local_off. A stuck sequencer state appears within one cycle as a missing done or err pulse, or as busy not falling.

// File: rtl/mbk_pkg.sv
package mbk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

    localparam logic [1:0] WID_8   = 2'b00;
    localparam logic [1:0] WID_16  = 2'b01;
    localparam logic [1:0] WID_32  = 2'b10;
    localparam logic [1:0] WID_RSV = 2'b11;
endpackage

// File: rtl/mbk_cfg_regs.sv
module mbk_cfg_regs
    import mbk_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int CNT_W     = 5,
    parameter int GW        = 10,
    parameter int SZ_W      = 8,
    parameter int SEL_W     = 4,
    parameter int WID_LSB   = 8,
    parameter int BANK_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [GW-1:0]    cfg_wdata,
    output logic [CNT_W-1:0] cyc_r [NBANK],
    output logic [1:0]       wid_r [NBANK],
    output logic [GW-1:0]    b7_base,
    output logic [SZ_W-1:0]  b7_size
);
    localparam logic [GW-1:0]   BASE_RST = GW'(NBANK - 1) << (GW - BANK_BITS);
    localparam logic [SZ_W-1:0] SIZE_RST = SZ_W'(1) << (GW - BANK_BITS);

    logic [1:0] wid_field;
    assign wid_field = cfg_wdata[WID_LSB +: 2];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic wr_hit;
        assign wr_hit = cfg_we && (cfg_sel == SEL_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cyc_r[b] <= '1;
                wid_r[b] <= WID_8;
            end else if (wr_hit && wid_field != WID_RSV) begin
                cyc_r[b] <= cfg_wdata[CNT_W-1:0];
                wid_r[b] <= wid_field;
            end
        end

        p_rsv_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wid_field == WID_RSV) |=> ($stable(cyc_r[b]) && $stable(wid_r[b])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b7_base <= BASE_RST;
            b7_size <= SIZE_RST;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(NBANK))
                b7_base <= cfg_wdata;
            if (cfg_sel == SEL_W'(NBANK + 1))
                b7_size <= cfg_wdata[SZ_W-1:0];
        end
    end
endmodule

// File: rtl/mbk_decode.sv
module mbk_decode #(
    parameter int ADDR_W    = 30,
    parameter int BANK_BITS = 3,
    parameter int GRAN_BITS = 20,
    parameter int GW        = 10,
    parameter int SZ_W      = 8,
    parameter int WIN_BITS  = 27
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [GW-1:0]        b7_base,
    input  logic [SZ_W-1:0]      b7_size,
    output logic                 hit,
    output logic [BANK_BITS-1:0] idx,
    output logic [WIN_BITS-1:0]  off
);
    localparam logic [BANK_BITS-1:0] LAST = '1;

    logic [BANK_BITS-1:0] top;
    logic [GW:0]          gran, lo, hi;
    logic                 in_last, b7_hit;
    logic [WIN_BITS-1:0]  off7;

    always_comb begin
        top     = addr[ADDR_W-1 -: BANK_BITS];
        gran    = {1'b0, addr[ADDR_W-1 -: GW]};
        lo      = {1'b0, b7_base};
        hi      = lo + (GW+1)'(b7_size);
        in_last = (top == LAST);
        b7_hit  = in_last && (gran >= lo) && (gran < hi);
        off7    = addr[WIN_BITS-1:0]
                - {b7_base[WIN_BITS-GRAN_BITS-1:0], {GRAN_BITS{1'b0}}};
        hit     = !in_last || b7_hit;
        idx     = top;
        off     = in_last ? off7 : addr[WIN_BITS-1:0];
    end
endmodule

// File: rtl/mbk_seq.sv
module mbk_seq
    import mbk_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int BANK_BITS = 3,
    parameter int CNT_W     = 5,
    parameter int WIN_BITS  = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 hit,
    input  logic [BANK_BITS-1:0] idx,
    input  logic [WIN_BITS-1:0]  off,
    input  logic [CNT_W-1:0]     cyc_sel,
    input  logic [1:0]           wid_sel,
    input  logic                 wait_in,
    output logic [NBANK-1:0]     bank_sel,
    output logic [1:0]           bus_width,
    output logic [WIN_BITS-1:0]  local_off,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    seq_state_t           state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [BANK_BITS-1:0] bank_q;
    logic [WIN_BITS-1:0]  off_q;
    logic [1:0]           wid_q;
    logic                 start;

    assign start = (state == ST_IDLE) && req && hit;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req) nxt = hit ? ST_ACTIVE : ST_FAULT;
            ST_ACTIVE: if (!wait_in && cnt == '0) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bank_q <= '0;
            off_q  <= '0;
            wid_q  <= '0;
        end else if (start) begin
            cnt    <= cyc_sel;
            bank_q <= idx;
            off_q  <= off;
            wid_q  <= wid_sel;
        end else if (state == ST_ACTIVE && !wait_in && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        bank_sel  = (state == ST_ACTIVE) ? (NBANK'(1) << bank_q) : '0;
        bus_width = wid_q;
        local_off = off_q;
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        err       = (state == ST_FAULT);
    end

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && wait_in) |=> (state == ST_ACTIVE && $stable(cnt) && $stable(bank_sel)));

    p_done_after_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_ACTIVE));

    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!busy && bank_sel == '0));

    p_busy_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && req && (wait_in || cnt != '0)) |=> (state == ST_ACTIVE && $stable(bank_sel)));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ACTIVE && cnt == $past(cyc_sel) && bus_width == $past(wid_sel)));
endmodule

// File: rtl/mem_bank_ctl.sv
module mem_bank_ctl
    import mbk_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int NBANK     = 8,
    parameter int CNT_W     = 5,
    parameter int GRAN_BITS = 20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [$clog2(NBANK+2)-1:0]         cfg_sel,
    input  logic [ADDR_W-GRAN_BITS-1:0]        cfg_wdata,
    input  logic                               req,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               wait_in,
    output logic [NBANK-1:0]                   bank_sel,
    output logic [1:0]                         bus_width,
    output logic [ADDR_W-$clog2(NBANK)-1:0]    local_off,
    output logic                               busy,
    output logic                               done,
    output logic                               err
);
    localparam int BANK_BITS = $clog2(NBANK);
    localparam int WIN_BITS  = ADDR_W - BANK_BITS;
    localparam int GW        = ADDR_W - GRAN_BITS;
    localparam int SZ_W      = WIN_BITS - GRAN_BITS + 1;
    localparam int SEL_W     = $clog2(NBANK + 2);
    localparam int WID_LSB   = 8;

    logic [CNT_W-1:0]     cyc_r [NBANK];
    logic [1:0]           wid_r [NBANK];
    logic [GW-1:0]        b7_base;
    logic [SZ_W-1:0]      b7_size;
    logic                 dec_hit;
    logic [BANK_BITS-1:0] dec_idx;
    logic [WIN_BITS-1:0]  dec_off;

    mbk_cfg_regs #(
        .NBANK(NBANK), .CNT_W(CNT_W), .GW(GW), .SZ_W(SZ_W),
        .SEL_W(SEL_W), .WID_LSB(WID_LSB), .BANK_BITS(BANK_BITS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cyc_r(cyc_r), .wid_r(wid_r),
        .b7_base(b7_base), .b7_size(b7_size)
    );

    mbk_decode #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .GRAN_BITS(GRAN_BITS),
        .GW(GW), .SZ_W(SZ_W), .WIN_BITS(WIN_BITS)
    ) u_dec (
        .addr(addr), .b7_base(b7_base), .b7_size(b7_size),
        .hit(dec_hit), .idx(dec_idx), .off(dec_off)
    );

    mbk_seq #(
        .NBANK(NBANK), .BANK_BITS(BANK_BITS), .CNT_W(CNT_W), .WIN_BITS(WIN_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .hit(dec_hit), .idx(dec_idx),
        .off(dec_off), .cyc_sel(cyc_r[dec_idx]), .wid_sel(wid_r[dec_idx]),
        .wait_in(wait_in), .bank_sel(bank_sel), .bus_width(bus_width),
        .local_off(local_off), .busy(busy), .done(done), .err(err)
    );

    p_fixed_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && addr[ADDR_W-1 -: BANK_BITS] != '1) |=> (bank_sel[$past(addr[ADDR_W-1 -: BANK_BITS])] && !err));
endmodule

// File: tb/sim_mem_bank_ctl.sv
module sim_mem_bank_ctl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_sel = 0;
    logic [9:0]  cfg_wdata = 0;
    logic        req = 0;
    logic [29:0] addr = 0;
    logic        wait_in = 0;
    logic [7:0]  bank_sel;
    logic [1:0]  bus_width;
    logic [26:0] local_off;
    logic        busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_m [8];
    int wid_m [8];

    always #10 clk = ~clk;

    mem_bank_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .addr(addr), .wait_in(wait_in),
        .bank_sel(bank_sel), .bus_width(bus_width), .local_off(local_off),
        .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = 10'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_bank(input int b, input int c, input int w);
        wr(b, (w << 8) | c);
        cyc_m[b] = c; wid_m[b] = w;
    endtask

    // poke: 1 = stray request at k==1, 2 = config write to bank mw_b at k==1
    task automatic access(input logic [29:0] a, input int nwait, input int eb,
                          input int ec, input int ew, input int eoff,
                          input int poke, input int mw_b, input int mw_d, input string tag);
        int  k = 0;
        int  act = 0;
        bit  first = 1;
        bit  seen = 0;
        @(negedge clk);
        req = 1; addr = a; wait_in = 0;
        @(negedge clk);
        req = 0;
        while (k < 300) begin
            req = 0; cfg_we = 0;
            if (done) begin seen = 1; break; end
            if (bank_sel != 0) begin
                act++;
                if (first) begin
                    first = 0;
                    chk(bank_sel == 8'(1 << eb), {tag, " sel"}, int'(bank_sel), 1 << eb);
                    chk(bus_width == 2'(ew), {tag, " width R8"}, int'(bus_width), ew);
                    chk(local_off == 27'(eoff), {tag, " offset"}, int'(local_off), eoff);
                end
            end
            wait_in = (k < nwait);
            if (k == 1 && poke == 1) begin req = 1; addr = {3'd2, 27'd77}; end
            if (k == 1 && poke == 2) begin cfg_we = 1; cfg_sel = 4'(mw_b); cfg_wdata = 10'(mw_d); end
            k++;
            @(negedge clk);
        end
        wait_in = 0; req = 0; cfg_we = 0;
        chk(seen, {tag, " done R6"}, int'(seen), 1);
        chk(act == ec + 1 + nwait, {tag, " select cycles R6 R7"}, act, ec + 1 + nwait);
        chk(bank_sel == 0, {tag, " no select at done R6"}, int'(bank_sel), 0);
        @(negedge clk);
        chk(!busy && !done, {tag, " idle after R6 R10"}, int'(busy), 0);
    endtask

    task automatic miss(input logic [29:0] a, input string tag);
        @(negedge clk);
        req = 1; addr = a;
        @(negedge clk);
        req = 0;
        chk(err && bank_sel == 0, {tag, " err R5"}, int'(err), 1);
        @(negedge clk);
        chk(!err && !busy, {tag, " err one cycle R5"}, int'(err), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [29:0] a;
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && bank_sel == 0, "R1 reset outputs", int'(busy), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && bank_sel == 0, "R1 idle after release", int'(bank_sel), 0);
        for (int b = 0; b < 8; b++) begin cyc_m[b] = 31; wid_m[b] = 0; end
        // R1 reset defaults: bank 7 whole top window, 31 cycles, width 00
        access({3'd7, 27'd5}, 0, 7, 31, 0, 5, 0, 0, 0, "R1 default bank7");
        access({3'd4, 27'd9}, 0, 4, 31, 0, 9, 0, 0, 0, "R1 default bank4");

        for (int b = 0; b < 8; b++) set_bank(b, (b * 7 + 2) % 32, b % 3);
        // R2 fixed banks, offsets at edges
        for (int b = 0; b < 7; b++) begin
            for (int j = 0; j < 3; j++) begin
                int o;
                o = (j == 0) ? 0 : (j == 1) ? 27'h7FFFFFF : b * 12345 + 1;
                access({3'(b), 27'(o)}, 0, b, cyc_m[b], wid_m[b], o, 0, 0, 0, "R2 fixed");
            end
        end
        // R6 R8 cycle count sweep on bank 0
        for (int c = 0; c < 32; c++) begin
            set_bank(0, c, c % 3);
            access({3'd0, 27'(c * 1000)}, 0, 0, c, c % 3, c * 1000, 0, 0, 0, "R6 sweep");
        end
        // R7 wait sweep
        for (int w = 0; w < 6; w++)
            access({3'd3, 27'd64}, w, 3, cyc_m[3], wid_m[3], 64, 0, 0, 0, "R7 wait");

        // R3 bank 7 window: base 900, size 10
        wr(8, 900); wr(9, 10);
        base = 900;
        a = {10'd905, 20'h12345};
        access(a, 0, 7, cyc_m[7], wid_m[7], int'(27'(a - (30'(base) << 20))), 0, 0, 0, "R3 inside");
        a = {10'd900, 20'h0};
        access(a, 0, 7, cyc_m[7], wid_m[7], 0, 0, 0, 0, "R3 lower bound");
        a = {10'd909, 20'hFFFFF};
        access(a, 1, 7, cyc_m[7], wid_m[7], int'(27'(a - (30'(base) << 20))), 0, 0, 0, "R3 upper edge");
        miss({10'd910, 20'h0}, "R3 R5 above window");
        miss({10'd899, 20'hFFFFF}, "R3 R5 below window");
        wr(9, 0);
        miss({10'd900, 20'h0}, "R3 R5 empty window");

        // R4 overlap: base 768 (bank 6), size 200
        wr(8, 768); wr(9, 200);
        access({10'd770, 20'h345}, 0, 6, cyc_m[6], wid_m[6], int'(27'({10'd770, 20'h345})), 0, 0, 0, "R4 fixed wins");
        a = {10'd901, 20'h0};
        access(a, 0, 7, cyc_m[7], wid_m[7], int'(27'(a - (30'd768 << 20))), 0, 0, 0, "R4 bank7 beyond");

        // R9 reserved width write dropped
        wr(2, (3 << 8) | 9);
        access({3'd2, 27'd1}, 0, 2, cyc_m[2], wid_m[2], 1, 0, 0, 0, "R9 reserved dropped");

        // R10 stray request during access
        access({3'd5, 27'd500}, 0, 5, cyc_m[5], wid_m[5], 500, 1, 0, 0, "R10 busy req");
        set_bank(1, 0, 2);
        access({3'd1, 27'd3}, 2, 1, 0, 2, 3, 1, 0, 0, "R10 short busy req");

        // R11 mid-access write to bank 1: old config holds, new applies next
        set_bank(1, 6, 1);
        access({3'd1, 27'd11}, 0, 1, 6, 1, 11, 2, 1, (2 << 8) | 3, "R11 current");
        cyc_m[1] = 3; wid_m[1] = 2;
        access({3'd1, 27'd12}, 0, 1, 3, 2, 12, 0, 0, 0, "R11 next");

        finish_run();
    end
endmodule